// File: doc/BRIEF.md
# UART Register Front End

This block is the software-facing half of a serial port. A bus master reaches it through a simple word-addressed read/write port. Writing the transmit-queue register pushes one byte into a 64-entry transmit FIFO. Reading the receive-queue register pops one byte from a 64-entry receive FIFO. A control register carries the path enables, the FIFO flush bits, a level-acting error clear and two interrupt enables. A status register reports FIFO occupancy flags, the transmitter's busy state and three sticky error flags. A level register holds the occupancy thresholds that drive a single level-sensitive interrupt line.

The serial bit engines sit outside the block. The transmit engine takes bytes through a valid/ready pair and reports whether it is still shifting. The receive engine offers each byte with a valid strobe, together with its parity and framing error indications. The divisor register is only stored and passed out to the external baud generator.

Byte offsets are 0x00 transmit queue, 0x04 receive queue, 0x08 control, 0x0C status, 0x10 thresholds and 0x14 divisor. Reads combine combinationally into `busRdData`. A receive pop and any register write take effect on the clock edge that ends the access.

Top module: `uart_mmio_front`

## Requirements
- R1: After reset, control, thresholds and divisor read zero, status reads 0x0050_0000 while `txBusy` is low, and `irq` is low.
- R2: Control keeps only bits 12 (TX enable), 13 (RX enable), 22 (TX flush), 23 (RX flush), 24 (error clear), 27 (RX interrupt enable) and 28 (TX interrupt enable). Thresholds keep bits [15:0] and the divisor keeps bits [24:0]. Every other bit, the transmit-queue offset, the offsets 0x18/0x1C and any address with bits [1:0] not zero read as zero, and writes to them change nothing.
- R3: A write to offset 0x00 queues bits [7:0]. `txValid` is high only while TX is enabled and the queue holds data. Bytes leave on `txData` in write order, one per cycle in which `txValid` and `txReady` are both high.
- R4: The transmit queue accepts 64 bytes. A write while it is full is dropped and sets status bit 18, and status bit 21 reads 1 while it is full.
- R5: While RX is enabled, each `rxValid` strobe queues `rxData`. A read of offset 0x04 with `busRdEn` returns {24'b0, oldest byte} and removes it. While RX is disabled, `rxValid` is ignored.
- R6: Reading offset 0x04 while the receive queue is empty returns zero and leaves the queue empty.
- R7: The receive queue holds 64 bytes. A further incoming byte is dropped and the 64 held bytes are unaffected.
- R8: Status bits 16 (parity) and 17 (framing) latch on an accepted byte that carries the matching error. Bits 16 to 18 stay set until control bit 24 is 1. They stay zero for as long as bit 24 stays 1, even when new errors arrive, and latch again once bit 24 returns to 0.
- R9: While control bit 22 (or 23) is 1, the transmit (or receive) queue is emptied and incoming bytes for it are dropped without raising an error.
- R10: Status bit 20 is receive-queue empty, 22 is transmit-queue empty and 25 follows `txBusy`.
- R11: `irq` is high when bit 27 and bit 13 are set and the receive occupancy is at least threshold bits [7:0].
- R12: `irq` is high when bit 28 is set and the transmit occupancy is at most threshold bits [15:8]. `irq` is the OR of the two sources.
- R13: `txEnable`, `rxEnable` and `baudCfg` present control bits 12 and 13 and the stored divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe (pops the receive queue at 0x04) |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the addressed register |
| txValid | output | 1 | Transmit byte available to the engine |
| txReady | input | 1 | Engine takes the byte |
| txData | output | 8 | Oldest transmit byte |
| txBusy | input | 1 | Engine is still shifting a frame |
| rxValid | input | 1 | Engine offers a received byte |
| rxData | input | 8 | Received byte |
| rxParErr | input | 1 | Parity error on the offered byte |
| rxFrmErr | input | 1 | Framing error on the offered byte |
| txEnable | output | 1 | Transmit path enable to the engine |
| rxEnable | output | 1 | Receive path enable to the engine |
| baudCfg | output | 25 | Stored divisor setting for the baud generator |
| irq | output | 1 | Level interrupt |

## Verification
The checker watches several properties on every cycle. Both occupancy counters stay within the queue depth. A flush leaves its queue empty on the next cycle. An asserted clear leaves the three error flags at zero on the next cycle. `txValid` never rises without an enable and stored data, an empty receive queue with no incoming byte stays empty, the receive interrupt condition always raises `irq`, and the busy flag tracks its input. Other behaviour shows only in the bench scenarios: byte ordering through both queues, the drop at 64 entries, the bit-by-bit writability of the control register, sticky errors surviving until the clear, and the threshold sweeps of both interrupt sources.

// File: rtl/uart_mmio_pkg.sv
package uart_mmio_pkg;

  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int THR_W  = 8;
  localparam int BAUD_W = 25;

  typedef enum logic [2:0] {
    SEL_TXQ  = 3'd0,
    SEL_RXQ  = 3'd1,
    SEL_CTRL = 3'd2,
    SEL_STAT = 3'd3,
    SEL_LVL  = 3'd4,
    SEL_BAUD = 3'd5,
    SEL_RSV6 = 3'd6,
    SEL_RSV7 = 3'd7
  } regSel_e;

  // control bit positions
  localparam int CB_TXON   = 12;
  localparam int CB_RXON   = 13;
  localparam int CB_TXFL   = 22;
  localparam int CB_RXFL   = 23;
  localparam int CB_ECLR   = 24;
  localparam int CB_RXIRQ  = 27;
  localparam int CB_TXIRQ  = 28;

  localparam logic [DATA_W-1:0] CTRL_MASK =
      (DATA_W'(1) << CB_TXON)  | (DATA_W'(1) << CB_RXON) |
      (DATA_W'(1) << CB_TXFL)  | (DATA_W'(1) << CB_RXFL) |
      (DATA_W'(1) << CB_ECLR)  | (DATA_W'(1) << CB_RXIRQ) |
      (DATA_W'(1) << CB_TXIRQ);

  // status bit positions
  localparam int SB_PAR    = 16;
  localparam int SB_FRM    = 17;
  localparam int SB_WERR   = 18;
  localparam int SB_RXEMP  = 20;
  localparam int SB_TXFULL = 21;
  localparam int SB_TXEMP  = 22;
  localparam int SB_BUSY   = 25;

  typedef struct packed {
    logic              txPush;
    logic              rxPop;
    logic              txFlush;
    logic              rxFlush;
    logic              errClear;
    logic              txOn;
    logic              rxOn;
    logic              txIrqOn;
    logic              rxIrqOn;
    logic [THR_W-1:0]  txLevelThr;
    logic [THR_W-1:0]  rxLevelThr;
    logic [BYTE_W-1:0] pushByte;
  } strobe_t;

endpackage

// File: rtl/uart_mmio_fifo.sv
module uart_mmio_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] headData,
  output logic [CNT_W-1:0] level,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (level == '0);
  assign full   = (level == CNT_W'(DEPTH));
  assign doPush = push && !full && !flush;
  assign doPop  = pop && !empty && !flush;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/uart_mmio_ctrl.sv
module uart_mmio_ctrl
  import uart_mmio_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic [DATA_W-1:0] statWord,
  input  logic [BYTE_W-1:0] rxHead,
  input  logic              rxEmpty,
  output strobe_t           stb,
  output logic [BAUD_W-1:0] baudCfg
);
  logic [DATA_W-1:0]  ctrlReg;
  logic [2*THR_W-1:0] lvlReg;
  logic [BAUD_W-1:0]  baudReg;
  logic               upperZero;
  logic               hit;
  regSel_e            sel;

  generate
    if (ADDR_W > 5) begin : g_wideAddr
      assign upperZero = (busAddr[ADDR_W-1:5] == '0);
    end else begin : g_narrowAddr
      assign upperZero = 1'b1;
    end
  endgenerate

  assign hit = upperZero && (busAddr[1:0] == 2'b00);
  assign sel = regSel_e'(busAddr[4:2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlReg <= '0;
      lvlReg  <= '0;
      baudReg <= '0;
    end else if (busWrEn && hit) begin
      case (sel)
        SEL_CTRL: ctrlReg <= busWrData & CTRL_MASK;
        SEL_LVL:  lvlReg  <= busWrData[2*THR_W-1:0];
        SEL_BAUD: baudReg <= busWrData[BAUD_W-1:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    stb            = '0;
    stb.txPush     = busWrEn && hit && (sel == SEL_TXQ);
    stb.rxPop      = busRdEn && hit && (sel == SEL_RXQ);
    stb.pushByte   = busWrData[BYTE_W-1:0];
    stb.txOn       = ctrlReg[CB_TXON];
    stb.rxOn       = ctrlReg[CB_RXON];
    stb.txFlush    = ctrlReg[CB_TXFL];
    stb.rxFlush    = ctrlReg[CB_RXFL];
    stb.errClear   = ctrlReg[CB_ECLR];
    stb.rxIrqOn    = ctrlReg[CB_RXIRQ];
    stb.txIrqOn    = ctrlReg[CB_TXIRQ];
    stb.rxLevelThr = lvlReg[THR_W-1:0];
    stb.txLevelThr = lvlReg[2*THR_W-1:THR_W];
  end

  always_comb begin
    busRdData = '0;
    if (hit) begin
      case (sel)
        SEL_RXQ:  busRdData = rxEmpty ? '0 : DATA_W'(rxHead);
        SEL_CTRL: busRdData = ctrlReg;
        SEL_STAT: busRdData = statWord;
        SEL_LVL:  busRdData = DATA_W'(lvlReg);
        SEL_BAUD: busRdData = DATA_W'(baudReg);
        default:  busRdData = '0;
      endcase
    end
  end

  assign baudCfg = baudReg;
endmodule

// File: rtl/uart_mmio_dpath.sv
module uart_mmio_dpath
  import uart_mmio_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  output logic              txValid,
  input  logic              txReady,
  output logic [BYTE_W-1:0] txData,
  input  logic              txBusy,
  input  logic              rxValid,
  input  logic [BYTE_W-1:0] rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  output logic [DATA_W-1:0] statWord,
  output logic [BYTE_W-1:0] rxHead,
  output logic              rxEmpty,
  output logic [CNT_W-1:0]  txLevel,
  output logic [CNT_W-1:0]  rxLevel,
  output logic              irq
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic txEmpty, txFull, rxFull;
  logic txTake, rxAccept;
  logic parFlag, frmFlag, wErrFlag;
  logic rxIrq, txIrq;

  assign txValid  = stb.txOn && !txEmpty && !stb.txFlush;
  assign txTake   = txValid && txReady;
  assign rxAccept = rxValid && stb.rxOn && !stb.rxFlush;

  uart_mmio_fifo #(.DEPTH(DEPTH), .W(BYTE_W), .CNT_W(CNT_W)) txQ_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (stb.txFlush),
    .push     (stb.txPush),
    .pushData (stb.pushByte),
    .pop      (txTake),
    .headData (txData),
    .level    (txLevel),
    .empty    (txEmpty),
    .full     (txFull)
  );

  uart_mmio_fifo #(.DEPTH(DEPTH), .W(BYTE_W), .CNT_W(CNT_W)) rxQ_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (stb.rxFlush),
    .push     (rxAccept),
    .pushData (rxData),
    .pop      (stb.rxPop),
    .headData (rxHead),
    .level    (rxLevel),
    .empty    (rxEmpty),
    .full     (rxFull)
  );

  // sticky errors: clear is level-acting and wins over new events
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parFlag  <= 1'b0;
      frmFlag  <= 1'b0;
      wErrFlag <= 1'b0;
    end else if (stb.errClear) begin
      parFlag  <= 1'b0;
      frmFlag  <= 1'b0;
      wErrFlag <= 1'b0;
    end else begin
      if (rxAccept && rxParErr) parFlag <= 1'b1;
      if (rxAccept && rxFrmErr) frmFlag <= 1'b1;
      if (stb.txPush && txFull && !stb.txFlush) wErrFlag <= 1'b1;
    end
  end

  always_comb begin
    statWord            = '0;
    statWord[SB_PAR]    = parFlag;
    statWord[SB_FRM]    = frmFlag;
    statWord[SB_WERR]   = wErrFlag;
    statWord[SB_RXEMP]  = rxEmpty;
    statWord[SB_TXFULL] = txFull;
    statWord[SB_TXEMP]  = txEmpty;
    statWord[SB_BUSY]   = txBusy;
  end

  assign rxIrq = stb.rxIrqOn && stb.rxOn &&
                 (CMP_W'(rxLevel) >= CMP_W'(stb.rxLevelThr));
  assign txIrq = stb.txIrqOn &&
                 (CMP_W'(txLevel) <= CMP_W'(stb.txLevelThr));
  assign irq   = rxIrq || txIrq;

  // receive-full has no status bit; a dropped byte leaves no trace
  logic unusedRxFull;
  assign unusedRxFull = rxFull;
endmodule

// File: rtl/uart_mmio_front.sv
module uart_mmio_front
  import uart_mmio_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              txValid,
  input  logic              txReady,
  output logic [7:0]        txData,
  input  logic              txBusy,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxParErr,
  input  logic              rxFrmErr,
  output logic              txEnable,
  output logic              rxEnable,
  output logic [24:0]       baudCfg,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  strobe_t           stb;
  logic [DATA_W-1:0] statWord;
  logic [BYTE_W-1:0] rxHead;
  logic              rxEmpty;
  logic [CNT_W-1:0]  txLevel, rxLevel;

  uart_mmio_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .statWord  (statWord),
    .rxHead    (rxHead),
    .rxEmpty   (rxEmpty),
    .stb       (stb),
    .baudCfg   (baudCfg)
  );

  uart_mmio_dpath #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dpath_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .txValid  (txValid),
    .txReady  (txReady),
    .txData   (txData),
    .txBusy   (txBusy),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .rxParErr (rxParErr),
    .rxFrmErr (rxFrmErr),
    .statWord (statWord),
    .rxHead   (rxHead),
    .rxEmpty  (rxEmpty),
    .txLevel  (txLevel),
    .rxLevel  (rxLevel),
    .irq      (irq)
  );

  assign txEnable = stb.txOn;
  assign rxEnable = stb.rxOn;
endmodule

// File: rtl/uart_mmio_front_chk.sv
module uart_mmio_front_chk
  import uart_mmio_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input strobe_t           stb,
  input logic              txValid,
  input logic              txBusy,
  input logic              rxValid,
  input logic              irq,
  input logic [CNT_W-1:0]  txLevel,
  input logic [CNT_W-1:0]  rxLevel,
  input logic [DATA_W-1:0] statWord
);
  a_r4_tx_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(txLevel) <= DEPTH);

  a_r7_rx_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rxLevel) <= DEPTH);

  a_r9_tx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    stb.txFlush |=> txLevel == '0);

  a_r9_rx_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rxFlush |=> rxLevel == '0);

  a_r8_clear_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stb.errClear |=> statWord[SB_WERR:SB_PAR] == 3'b000);

  a_r3_valid_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    txValid |-> (stb.txOn && txLevel != '0));

  a_r6_empty_stays_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rxLevel == '0 && !rxValid) |=> rxLevel == '0);

  a_r11_rx_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rxIrqOn && stb.rxOn && int'(rxLevel) >= int'(stb.rxLevelThr)) |-> irq);

  a_r10_busy_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    statWord[SB_BUSY] == txBusy);
endmodule

bind uart_mmio_front uart_mmio_front_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .stb      (stb),
  .txValid  (txValid),
  .txBusy   (txBusy),
  .rxValid  (rxValid),
  .irq      (irq),
  .txLevel  (txLevel),
  .rxLevel  (rxLevel),
  .statWord (statWord)
);

// File: tb/uart_mmio_front_tb_top.sv
module uart_mmio_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;
  localparam logic [31:0] B_TXON  = 32'h1 << 12;
  localparam logic [31:0] B_RXON  = 32'h1 << 13;
  localparam logic [31:0] B_TXFL  = 32'h1 << 22;
  localparam logic [31:0] B_RXFL  = 32'h1 << 23;
  localparam logic [31:0] B_ECLR  = 32'h1 << 24;
  localparam logic [31:0] B_RXIRQ = 32'h1 << 27;
  localparam logic [31:0] B_TXIRQ = 32'h1 << 28;
  localparam logic [31:0] MASK = B_TXON | B_RXON | B_TXFL | B_RXFL | B_ECLR | B_RXIRQ | B_TXIRQ;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] busAddr = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic txValid, txEnable, rxEnable, irq;
  logic txReady = 1'b0, txBusy = 1'b0;
  logic [7:0] txData;
  logic rxValid = 1'b0, rxParErr = 1'b0, rxFrmErr = 1'b0;
  logic [7:0] rxData = '0;
  logic [24:0] baudCfg;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_mmio_front dut_i (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .txValid(txValid), .txReady(txReady),
    .txData(txData), .txBusy(txBusy), .rxValid(rxValid), .rxData(rxData),
    .rxParErr(rxParErr), .rxFrmErr(rxFrmErr), .txEnable(txEnable), .rxEnable(rxEnable),
    .baudCfg(baudCfg), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic rxSend(input logic [7:0] b, input logic pe, input logic fe);
    @(negedge clk);
    rxData = b; rxParErr = pe; rxFrmErr = fe; rxValid = 1'b1;
    @(negedge clk);
    rxValid = 1'b0; rxParErr = 1'b0; rxFrmErr = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(5'h08, rd); check("R1 ctrl", rd, 32'h0);
    peek(5'h0C, rd); check("R1 status", rd, 32'h0050_0000);
    peek(5'h10, rd); check("R1 thr", rd, 32'h0);
    peek(5'h14, rd); check("R1 baud", rd, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2 control bit sweep, R13 enable ports
    for (int i = 0; i < 32; i++) begin
      busWrite(5'h08, 32'h1 << i);
      peek(5'h08, rd);
      check("R2 ctrl bit", rd, (32'h1 << i) & MASK);
      if (i == 12) check("R13 txEnable", {31'b0, txEnable}, 32'h1);
      if (i == 13) check("R13 rxEnable", {31'b0, rxEnable}, 32'h1);
    end
    busWrite(5'h08, 32'h0);
    busWrite(5'h10, 32'hFFFF_FFFF);
    peek(5'h10, rd); check("R2 thr width", rd, 32'h0000_FFFF);
    busWrite(5'h14, 32'hFFFF_FFFF);
    peek(5'h14, rd); check("R2 baud width", rd, 32'h01FF_FFFF);
    check("R13 baudCfg", {7'b0, baudCfg}, 32'h01FF_FFFF);
    busWrite(5'h15, 32'h0);
    peek(5'h14, rd); check("R2 misaligned write ignored", rd, 32'h01FF_FFFF);
    peek(5'h16, rd); check("R2 misaligned read zero", rd, 32'h0);
    busWrite(5'h18, 32'hFFFF_FFFF);
    peek(5'h18, rd); check("R2 offset 0x18", rd, 32'h0);
    peek(5'h1C, rd); check("R2 offset 0x1C", rd, 32'h0);
    busWrite(5'h10, 32'h0);

    // R3/R4 transmit queue fill with engine disabled
    for (int i = 0; i < DEPTH; i++) busWrite(5'h00, {24'h0, pat(i)});
    peek(5'h00, rd); check("R2 txq reads zero", rd, 32'h0);
    peek(5'h0C, rd);
    check("R4 full flag", {31'b0, rd[21]}, 32'h1);
    check("R4 no error yet", {31'b0, rd[18]}, 32'h0);
    check("R3 no valid while disabled", {31'b0, txValid}, 32'h0);
    busWrite(5'h00, 32'h0000_00EE);
    peek(5'h0C, rd); check("R4 overflow error", {31'b0, rd[18]}, 32'h1);
    busWrite(5'h08, B_TXON);
    @(negedge clk);
    txReady = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      check("R3 valid", {31'b0, txValid}, 32'h1);
      check("R3 order", {24'h0, txData}, {24'h0, pat(i)});
      @(negedge clk);
    end
    txReady = 1'b0;
    #1 check("R4 dropped byte absent", {31'b0, txValid}, 32'h0);
    peek(5'h0C, rd); check("R10 tx empty", {31'b0, rd[22]}, 32'h1);

    // R8 clear of write error
    busWrite(5'h08, B_TXON | B_ECLR);
    busWrite(5'h08, B_TXON);
    peek(5'h0C, rd); check("R8 werr cleared", {29'b0, rd[18:16]}, 32'h0);

    // R10 busy
    txBusy = 1'b1;
    peek(5'h0C, rd); check("R10 busy", {31'b0, rd[25]}, 32'h1);
    txBusy = 1'b0;

    // R5 ignored while disabled
    busWrite(5'h08, 32'h0);
    rxSend(8'h5A, 1'b0, 1'b0);
    peek(5'h0C, rd); check("R5 rx disabled ignored", {31'b0, rd[20]}, 32'h1);

    // R5/R7 receive fill and drain
    busWrite(5'h08, B_RXON);
    for (int i = 0; i <= DEPTH; i++) rxSend(pat(i + 100), 1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      busRead(5'h04, rd);
      check("R7 rx order", rd, {24'h0, pat(i + 100)});
    end
    busRead(5'h04, rd); check("R6 empty read zero", rd, 32'h0);
    peek(5'h0C, rd); check("R6 still empty", {31'b0, rd[20]}, 32'h1);
    rxSend(8'h3C, 1'b0, 1'b0);
    busRead(5'h04, rd); check("R6 no stray pop", rd, 32'h0000_003C);

    // R8 sticky errors
    rxSend(8'h01, 1'b1, 1'b0);
    peek(5'h0C, rd); check("R8 parity latched", {30'b0, rd[17:16]}, 32'h1);
    rxSend(8'h02, 1'b0, 1'b1);
    rxSend(8'h03, 1'b0, 1'b0);
    peek(5'h0C, rd); check("R8 both sticky", {30'b0, rd[17:16]}, 32'h3);
    busWrite(5'h08, B_RXON | B_ECLR);
    rxSend(8'h04, 1'b1, 1'b1);
    peek(5'h0C, rd); check("R8 held clear", {30'b0, rd[17:16]}, 32'h0);
    busWrite(5'h08, B_RXON);
    peek(5'h0C, rd); check("R8 stays clear", {30'b0, rd[17:16]}, 32'h0);
    rxSend(8'h05, 1'b0, 1'b1);
    peek(5'h0C, rd); check("R8 relatch", {30'b0, rd[17:16]}, 32'h2);

    // R9 flushes
    busWrite(5'h08, B_RXON | B_RXFL);
    peek(5'h0C, rd); check("R9 rx flushed", {31'b0, rd[20]}, 32'h1);
    rxSend(8'h77, 1'b0, 1'b0);
    peek(5'h0C, rd); check("R9 rx drop while held", {31'b0, rd[20]}, 32'h1);
    busWrite(5'h08, B_ECLR);
    busWrite(5'h08, 32'h0);
    busWrite(5'h00, 32'h11);
    busWrite(5'h00, 32'h22);
    busWrite(5'h08, B_TXFL);
    busWrite(5'h00, 32'h33);
    peek(5'h0C, rd);
    check("R9 tx flushed", {31'b0, rd[22]}, 32'h1);
    check("R9 no error on drop", {31'b0, rd[18]}, 32'h0);
    busWrite(5'h08, 32'h0);

    // R11 receive threshold sweep
    for (int t = 0; t < 5; t++) begin
      for (int k = 0; k < 5; k++) begin
        busWrite(5'h10, 32'(t));
        busWrite(5'h08, B_RXON | B_RXIRQ | B_RXFL);
        busWrite(5'h08, B_RXON | B_RXIRQ);
        for (int j = 0; j < k; j++) rxSend(8'(j), 1'b0, 1'b0);
        #1 check("R11 rx irq", {31'b0, irq}, {31'b0, (k >= t)});
      end
    end
    busWrite(5'h08, B_RXIRQ);
    #1 check("R11 needs rx enable", {31'b0, irq}, 32'h0);
    busWrite(5'h08, B_RXFL);

    // R12 transmit threshold sweep
    for (int t = 0; t < 4; t++) begin
      for (int k = 0; k < 4; k++) begin
        busWrite(5'h10, 32'(t) << 8);
        busWrite(5'h08, B_TXIRQ | B_TXFL);
        busWrite(5'h08, B_TXIRQ);
        for (int j = 0; j < k; j++) busWrite(5'h00, 32'(j));
        #1 check("R12 tx irq", {31'b0, irq}, {31'b0, (k <= t)});
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule